// File: doc/BRIEF.md
# Integer Reference Clock Divider

This block divides a fast reference clock by an integer ratio held in a 5-bit control field. Software chooses the ratio so that the divided clock lands near 1 MHz for a slow timekeeping domain. The block drives two outputs: the divided clock itself, and a single-cycle enable pulse, in the reference domain, that marks each rising edge of that clock. Logic that stays on the reference clock can use the pulse in place of the derived clock.

Ratios 2 through 31 are supported, both odd and even. An odd ratio gives a high phase one reference cycle shorter than the low phase. Field values 0 and 1 switch the output off and hold it low. A new field value is captured only at the boundary between two output periods. Because of this, a ratio change or a stop request never cuts a high or low phase short. The ratio should be programmed before the divided clock is selected as a source further downstream.

Top module: `refclk_divider`

## Requirements
- R1: While `rst` is high at a clock edge, both `div_clk` and `div_tick` are low after that edge.
- R2: While the divider is stopped and `div_code` is 0 or 1, `div_clk` stays low and `div_tick` never pulses.
- R3: For a code N from 2 to 31, each output period lasts exactly N reference cycles.
- R4: Each period starts with its high phase. The high phase lasts floor(N/2) cycles and the low phase lasts N − floor(N/2) cycles.
- R5: `div_tick` is high for exactly one cycle per period: the first cycle in which `div_clk` is high.
- R6: A change of `div_code` while the divider is running takes effect only after the current period has finished with its old high and low lengths. The next period then uses the new ratio.
- R7: Changing to code 0 or 1 while running lets the current period finish. After that, `div_clk` stays low with no further `div_tick`.
- R8: When the divider is stopped or has just left reset, a code from 2 to 31 present at a clock edge makes `div_clk` and `div_tick` high right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_code | input | 5 | Divide ratio; 0 and 1 stop the output |
| div_clk | output | 1 | Divided clock, registered |
| div_tick | output | 1 | One-cycle pulse at each rising edge of `div_clk` |

## Verification
A wrong phase count or a wrong captured ratio changes the length of the very next high or low run of `div_clk`. It is therefore visible within one output period, and at most 31 reference cycles later. A boundary decision taken at the wrong moment produces one of two visible faults: a period with the old and new lengths mixed, or an output that starts or stops one cycle off. A sweep over every ratio, together with changes made in the middle of a period, exposes both. A tick that has come loose from the clock shows up as a period with zero or two ticks.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

    localparam int DIV_W   = 5;
    localparam int MIN_DIV = 2;
    localparam int MAX_DIV = (1 << DIV_W) - 1;
    localparam int MAX_HI  = MAX_DIV / 2;

    typedef logic [DIV_W-1:0] div_t;

    // Live divider state: run flag, captured ratio, phase position
    typedef struct packed {
        logic run;
        div_t ratio;
        div_t phase;
    } div_state_t;

    localparam div_state_t IDLE_STATE = '{run: 1'b0, ratio: '0, phase: '0};

    function automatic logic code_runs(input div_t code);
        return code >= div_t'(MIN_DIV);
    endfunction

    function automatic div_t high_len(input div_t n);
        return n >> 1;
    endfunction

    function automatic logic period_done(input div_state_t s);
        return !s.run || (s.phase == s.ratio - div_t'(1));
    endfunction

endpackage

// File: rtl/refdiv_next.sv
module refdiv_next
    import refdiv_pkg::*;
(
    input  div_state_t cur,
    input  div_t       code,
    output div_state_t nxt
);
    always_comb begin
        nxt = cur;
        if (period_done(cur)) begin
            if (code_runs(code)) begin
                nxt.run   = 1'b1;
                nxt.ratio = code;
                nxt.phase = '0;
            end else begin
                nxt = IDLE_STATE;
            end
        end else begin
            nxt.phase = cur.phase + div_t'(1);
        end
    end
endmodule

// File: rtl/refdiv_state.sv
module refdiv_state
    import refdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  div_state_t nxt,
    output div_state_t cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= IDLE_STATE;
        else     cur <= nxt;
    end
endmodule

// File: rtl/refdiv_shape.sv
module refdiv_shape
    import refdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  div_state_t nxt,
    output logic       clk_q,
    output logic       tick_q
);
    logic hi_d;
    logic first_d;

    always_comb begin
        hi_d    = nxt.run && (nxt.phase < high_len(nxt.ratio));
        first_d = nxt.run && (nxt.phase == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q  <= 1'b0;
            tick_q <= 1'b0;
        end else begin
            clk_q  <= hi_d;
            tick_q <= first_d;
        end
    end
endmodule

// File: rtl/refclk_divider.sv
module refclk_divider
    import refdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_code,
    output logic             div_clk,
    output logic             div_tick
);
    div_state_t st_cur;
    div_state_t st_nxt;

    refdiv_next u_next (
        .cur  (st_cur),
        .code (div_code),
        .nxt  (st_nxt)
    );

    refdiv_state u_state (
        .clk (clk),
        .rst (rst),
        .nxt (st_nxt),
        .cur (st_cur)
    );

    refdiv_shape u_shape (
        .clk    (clk),
        .rst    (rst),
        .nxt    (st_nxt),
        .clk_q  (div_clk),
        .tick_q (div_tick)
    );
endmodule

// File: rtl/refclk_divider_chk.sv
module refclk_divider_chk
    import refdiv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [DIV_W-1:0] div_code,
    input logic             div_clk,
    input logic             div_tick
);
    logic rst_q;
    div_t hi_run;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || !div_clk)       hi_run <= '0;
        else if (hi_run != '1)     hi_run <= hi_run + div_t'(1);
        // R1
        if (rst_q) reset_low_chk: assert (!div_clk && !div_tick);
    end

    // R5
    tick_in_high_chk: assert property (@(posedge clk) disable iff (rst)
        div_tick |-> div_clk);

    // R5
    rise_has_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(div_clk) |-> div_tick);

    // R2
    low_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (!div_clk && (div_code < div_t'(MIN_DIV))) |=> (!div_clk && !div_tick));

    // R4
    hi_run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        div_clk |-> (hi_run < div_t'(MAX_HI)));
endmodule

bind refclk_divider refclk_divider_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_code (div_code),
    .div_clk  (div_clk),
    .div_tick (div_tick)
);

// File: tb/tb_refclk_divider.sv
module tb_refclk_divider;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] div_code;
    logic       div_clk;
    logic       div_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    refclk_divider dut (
        .clk      (clk),
        .rst      (rst),
        .div_code (div_code),
        .div_clk  (div_clk),
        .div_tick (div_tick)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(input string req);
        int guard = 0;
        while (!div_tick && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(div_tick, req, 0, 1);
    endtask

    // Measures one period starting at a tick; optional code change at step chg_at
    task automatic measure(input int exp_h, input int exp_l, input int chg_at,
                           input logic [4:0] chg_code, input string req);
        int h = 0, l = 0, ticks = 0, step = 0;
        bit seen_low = 1'b0, bad_shape = 1'b0;
        do begin
            if (step == chg_at) div_code = chg_code;
            if (div_tick) ticks++;
            if (div_clk) begin
                h++;
                if (seen_low) bad_shape = 1'b1;
            end else begin
                l++;
                seen_low = 1'b1;
            end
            @(negedge clk);
            step++;
        end while (!div_tick && step < 100);
        chk(h == exp_h, {req, " high"}, h, exp_h);
        chk(l == exp_l, {req, " low"}, l, exp_l);
        chk(ticks == 1 && !bad_shape, {req, " tick/shape"}, ticks, 1);
    endtask

    task automatic stop_run(input int n, input logic [4:0] scode, input int at);
        int h = 0, stray = 0;
        div_code = 5'(n);
        @(negedge clk);
        wait_tick("R7 start");
        for (int i = 0; i < n; i++) begin
            if (i == at) div_code = scode;
            if (div_clk) h++;
            @(negedge clk);
        end
        chk(h == n / 2, "R7 last period high", h, n / 2);
        for (int i = 0; i < 150; i++) begin
            if (div_clk || div_tick) stray++;
            @(negedge clk);
        end
        chk(stray == 0, "R7 stays low", stray, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int stray;
        rst = 1'b1;
        div_code = 5'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!div_clk && !div_tick, "R1 reset", int'(div_clk), 0);
        rst = 1'b0;

        // R2 codes 0 and 1 keep output low
        stray = 0;
        for (int c = 0; c < 2; c++) begin
            div_code = 5'(c);
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (div_clk || div_tick) stray++;
            end
        end
        chk(stray == 0, "R2 stopped", stray, 0);

        // R8 start from stopped
        div_code = 5'd6;
        @(negedge clk);
        chk(div_clk && div_tick, "R8 immediate start", int'(div_clk), 1);

        // R3 R4 R5 full sweep of ratios
        for (int n = 2; n < 32; n++) begin
            div_code = 5'(n);
            @(negedge clk);
            wait_tick("R3 sync");
            measure(n / 2, n - n / 2, -1, 5'(n), $sformatf("R3/R4/R5 n=%0d", n));
        end

        // R6 mid-period change: finish old period, then new ratio
        div_code = 5'd20;
        @(negedge clk);
        wait_tick("R6 sync");
        measure(10, 10, -1, 5'd20, "R6 base");
        measure(10, 10, 3, 5'd7, "R6 old period kept");
        measure(3, 4, -1, 5'd7, "R6 new ratio");
        measure(3, 4, 5, 5'd2, "R6 change in low phase");
        measure(1, 1, -1, 5'd2, "R6 ratio 2");

        // R7 stop requests
        stop_run(9, 5'd1, 2);
        stop_run(2, 5'd0, 0);
        stop_run(31, 5'd0, 30);

        // R1 reset while running, then R8 restart after reset
        div_code = 5'd12;
        @(negedge clk);
        wait_tick("R1 sync");
        repeat (2) @(negedge clk);
        rst = 1'b1;
        stray = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (div_clk || div_tick) stray++;
        end
        chk(stray == 0, "R1 reset while running", stray, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(div_clk && div_tick, "R8 start after reset", int'(div_tick), 1);
        measure(6, 6, -1, 5'd12, "R8 first period");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule